// File: doc/BRIEF.md
# Zero-Gap Bit Expander with Lane Merge

This block spreads the bits of each source word apart by placing a chosen number of zero bits between neighbouring bits. It then moves the spread word up by a chosen offset. Because the gap and the offset are operands given with each request, the block can build interleaves of any degree. Each operand is spread with a gap of M-1 and given its own offset, and the results are ORed together. A plain two-input interleave could not do this without a wide operand list.

The top holds several expander lanes. Each lane has its own source word, gap and offset. A lane-enable mask chooses which lanes take part in the OR merge, so one to four operands can be combined in one request. A destination position above the top of the result word is dropped. When a set source bit of an enabled lane is lost this way, a truncation flag goes high. The result, the flag and the output strobe come out of one register stage.

Top module: `bitexp_top`

## Requirements
- R1: For an enabled lane with gap G and offset OFF, source bit i appears at result bit i*(G+1)+OFF. Every other result bit that lane produces is zero.
- R2: Lane k takes its source from src_bus[k*32 +: 32], its gap from gap_bus[k*2 +: 2] (range 0 to 3) and its offset from off_bus[k*3 +: 3] (range 0 to 7).
- R3: A source bit whose destination is above bit 127 is dropped. out_trunc is 1 exactly when at least one dropped bit of an enabled lane is set.
- R4: With G=0 and OFF=0 on a single enabled lane, out_data equals that lane's source, zero-extended to 128 bits.
- R5: out_data is the OR of the results of the lanes whose bit in lane_en is 1. A lane whose bit is 0 changes neither out_data nor out_trunc.
- R6: With M lanes enabled (M = 2, 3 or 4), all with G=M-1 and lane j given offset j, out_data is the M-way Morton interleave: bit M*i+j equals bit i of lane j.
- R7: out_valid is 1 in the cycle after a clock edge that samples in_valid=1, and 0 after an edge that samples in_valid=0.
- R8: While in_valid is 0, out_data and out_trunc keep their values, whatever the other inputs do.
- R9: After reset, out_valid, out_data and out_trunc are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| lane_en | input | 4 | One enable bit per lane |
| src_bus | input | 128 | Four 32-bit source words, lane 0 in the low bits |
| gap_bus | input | 8 | Four 2-bit gap counts |
| off_bus | input | 12 | Four 3-bit offsets |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_data | output | 128 | Merged expanded result |
| out_trunc | output | 1 | A set bit was dropped above bit 127 |

## Verification
The bench runs every gap and offset pair on a single lane against several bit patterns. These include all ones and a lone top bit, so the largest offsets push set bits past bit 127. A design that clamps the destination instead of dropping it, or that raises the flag for dropped zero bits, fails there. Morton merges of two, three and four lanes catch a lane that takes the wrong offset or gap field. A design that lets a disabled lane leak into the OR or into the flag shows up as extra result bits or a spurious flag. A register that loads without the strobe is caught by changing the inputs while the strobe is low.

// File: rtl/bitexp_pkg.sv
package bitexp_pkg;
   // Largest value an unsigned field of the given width can hold
   function automatic int field_max(input int bits);
      return (1 << bits) - 1;
   endfunction

   // Width of the window that holds a spread and shifted word without loss
   function automatic int window_width(input int src_w, input int gap_w, input int off_w);
      return src_w * (field_max(gap_w) + 1) + field_max(off_w);
   endfunction
endpackage

// File: rtl/bitexp_spread.sv
// Fixed-gap spreader: places source bit i at position i*(GAP+1)
module bitexp_spread #(
   parameter int SRC_W = 32,
   parameter int GAP   = 0,
   parameter int WIN_W = 135
) (
   input  logic [SRC_W-1:0] src,
   output logic [WIN_W-1:0] spread
);
   localparam int STRIDE = GAP + 1;
   localparam int TOP    = (SRC_W - 1) * STRIDE;

   if (TOP >= WIN_W) begin : g_bad_window
      $error("bitexp_spread: window too narrow for gap");
   end

   always_comb begin
      spread = '0;
      for (int i = 0; i < SRC_W; i++) begin
         spread[i*STRIDE] = src[i];
      end
   end
endmodule

// File: rtl/bitexp_lane.sv
// One expander lane: spread variants, gap select, offset shift, overflow detect
module bitexp_lane
   import bitexp_pkg::*;
#(
   parameter int SRC_W = 32,
   parameter int GAP_W = 2,
   parameter int OFF_W = 3,
   parameter int OUT_W = 128
) (
   input  logic [SRC_W-1:0] src,
   input  logic [GAP_W-1:0] gap,
   input  logic [OFF_W-1:0] off,
   output logic [OUT_W-1:0] data,
   output logic             trunc
);
   localparam int GAP_N = field_max(GAP_W) + 1;
   localparam int WIN_W = window_width(SRC_W, GAP_W, OFF_W);

   logic [WIN_W-1:0] variant [GAP_N];
   logic [WIN_W-1:0] picked;
   logic [WIN_W-1:0] shifted;

   for (genvar g = 0; g < GAP_N; g++) begin : g_gap
      bitexp_spread #(
         .SRC_W(SRC_W),
         .GAP  (g),
         .WIN_W(WIN_W)
      ) u_spread (
         .src   (src),
         .spread(variant[g])
      );
   end

   assign picked  = variant[gap];
   assign shifted = picked << off;

   if (WIN_W > OUT_W) begin : g_clip
      assign data  = shifted[OUT_W-1:0];
      assign trunc = |shifted[WIN_W-1:OUT_W];
   end else if (WIN_W == OUT_W) begin : g_exact
      assign data  = shifted;
      assign trunc = 1'b0;
   end else begin : g_pad
      assign data  = {{(OUT_W-WIN_W){1'b0}}, shifted};
      assign trunc = 1'b0;
   end
endmodule

// File: rtl/bitexp_merge.sv
// OR merge of enabled lane results and their truncation flags
module bitexp_merge #(
   parameter int LANES = 4,
   parameter int OUT_W = 128
) (
   input  logic [LANES-1:0]       en,
   input  logic [LANES*OUT_W-1:0] lane_data,
   input  logic [LANES-1:0]       lane_trunc,
   output logic [OUT_W-1:0]       merged,
   output logic                   any_trunc
);
   logic [OUT_W-1:0] acc [LANES+1];

   assign acc[0] = '0;
   for (genvar k = 0; k < LANES; k++) begin : g_or
      assign acc[k+1] = acc[k] | (lane_data[k*OUT_W +: OUT_W] & {OUT_W{en[k]}});
   end

   assign merged    = acc[LANES];
   assign any_trunc = |(lane_trunc & en);
endmodule

// File: rtl/bitexp_top.sv
// Multi-lane bit expander with OR merge and one output register stage
module bitexp_top
   import bitexp_pkg::*;
#(
   parameter int LANES = 4,
   parameter int SRC_W = 32,
   parameter int GAP_W = 2,
   parameter int OFF_W = 3,
   parameter int OUT_W = 128
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [LANES-1:0]       lane_en,
   input  logic [LANES*SRC_W-1:0] src_bus,
   input  logic [LANES*GAP_W-1:0] gap_bus,
   input  logic [LANES*OFF_W-1:0] off_bus,
   output logic                   out_valid,
   output logic [OUT_W-1:0]       out_data,
   output logic                   out_trunc
);
   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("bitexp_top: LANES must be 1..8");
   end
   if (SRC_W < 2) begin : g_bad_src
      $error("bitexp_top: SRC_W must be at least 2");
   end
   if (GAP_W < 1 || OFF_W < 1) begin : g_bad_fields
      $error("bitexp_top: field widths must be positive");
   end
   if (OUT_W < SRC_W) begin : g_bad_out
      $error("bitexp_top: OUT_W must cover SRC_W");
   end

   logic [LANES*OUT_W-1:0] lane_data;
   logic [LANES-1:0]       lane_trunc;
   logic [OUT_W-1:0]       merged;
   logic                   any_trunc;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      bitexp_lane #(
         .SRC_W(SRC_W),
         .GAP_W(GAP_W),
         .OFF_W(OFF_W),
         .OUT_W(OUT_W)
      ) u_lane (
         .src  (src_bus[k*SRC_W +: SRC_W]),
         .gap  (gap_bus[k*GAP_W +: GAP_W]),
         .off  (off_bus[k*OFF_W +: OFF_W]),
         .data (lane_data[k*OUT_W +: OUT_W]),
         .trunc(lane_trunc[k])
      );
   end

   bitexp_merge #(
      .LANES(LANES),
      .OUT_W(OUT_W)
   ) u_merge (
      .en        (lane_en),
      .lane_data (lane_data),
      .lane_trunc(lane_trunc),
      .merged    (merged),
      .any_trunc (any_trunc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_trunc <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data  <= merged;
            out_trunc <= any_trunc;
         end
      end
   end
endmodule

// File: rtl/bitexp_chk.sv
// Property checker for bitexp_top, attached by bind
module bitexp_chk #(
   parameter int LANES = 4,
   parameter int SRC_W = 32,
   parameter int GAP_W = 2,
   parameter int OFF_W = 3,
   parameter int OUT_W = 128
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic [LANES-1:0]       lane_en,
   input logic [LANES*SRC_W-1:0] src_bus,
   input logic [LANES*GAP_W-1:0] gap_bus,
   input logic [LANES*OFF_W-1:0] off_bus,
   input logic                   out_valid,
   input logic [OUT_W-1:0]       out_data,
   input logic                   out_trunc
);
   localparam int GAP_MAX  = (1 << GAP_W) - 1;
   localparam int SAFE_OFF = OUT_W - 1 - (SRC_W - 1) * (GAP_MAX + 1);

   logic             all_safe;
   logic [SRC_W-1:0] src0;
   logic             solo_ident;
   logic             solo_safe;

   always_comb begin
      all_safe = 1'b1;
      for (int k = 0; k < LANES; k++) begin
         if (lane_en[k] && (int'(off_bus[k*OFF_W +: OFF_W]) > SAFE_OFF)) all_safe = 1'b0;
      end
   end

   assign src0       = src_bus[SRC_W-1:0];
   assign solo_ident = (lane_en == LANES'(1)) && (gap_bus[GAP_W-1:0] == '0)
                       && (off_bus[OFF_W-1:0] == '0);
   assign solo_safe  = (lane_en == LANES'(1)) && (int'(off_bus[OFF_W-1:0]) <= SAFE_OFF);

   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R7
   AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R7
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_data) && $stable(out_trunc))); // R8
   AST_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && solo_ident) |=> (out_data == OUT_W'($past(src0)))); // R4
   AST_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_en == '0) |=> (out_data == '0 && !out_trunc)); // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && all_safe) |=> !out_trunc); // R3
   AST_BIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && solo_safe) |=> ($countones(out_data) == $countones($past(src0)))); // R1
endmodule

bind bitexp_top bitexp_chk u_chk (.*);

// File: tb/sim_bitexp_top.sv
module sim_bitexp_top;
   localparam int LANES = 4;
   localparam int SW    = 32;
   localparam int OW    = 128;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic [LANES-1:0]   lane_en = '0;
   logic [LANES*SW-1:0] src_bus = '0;
   logic [LANES*2-1:0] gap_bus = '0;
   logic [LANES*3-1:0] off_bus = '0;
   logic               out_valid;
   logic [OW-1:0]      out_data;
   logic               out_trunc;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   logic [31:0] seed = 32'h1357_9bdf;

   always #2 clk = ~clk;

   bitexp_top u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_en(lane_en),
      .src_bus(src_bus), .gap_bus(gap_bus), .off_bus(off_bus),
      .out_valid(out_valid), .out_data(out_data), .out_trunc(out_trunc)
   );

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      return s * 32'd1664525 + 32'd1013904223;
   endfunction

   // Expected merged result from the placement rule
   function automatic logic [OW:0] model(input logic [LANES-1:0] en,
                                        input logic [LANES*SW-1:0] s,
                                        input logic [LANES*2-1:0] g,
                                        input logic [LANES*3-1:0] o);
      logic [OW-1:0] d = '0;
      logic          t = 1'b0;
      for (int k = 0; k < LANES; k++) begin
         if (en[k]) begin
            for (int i = 0; i < SW; i++) begin
               int pos = i * (int'(g[k*2 +: 2]) + 1) + int'(o[k*3 +: 3]);
               if (s[k*SW + i]) begin
                  if (pos < OW) d[pos] = 1'b1;
                  else t = 1'b1;
               end
            end
         end
      end
      return {t, d};
   endfunction

   task automatic check(input string req, input logic [OW-1:0] exp_d,
                        input logic exp_t, input logic exp_v);
      total++;
      if (out_data !== exp_d || out_trunc !== exp_t || out_valid !== exp_v) begin
         bad++;
         $display("FAIL %s: data=%h trunc=%b valid=%b expected data=%h trunc=%b valid=%b",
                  req, out_data, out_trunc, out_valid, exp_d, exp_t, exp_v);
      end
   endtask

   task automatic fire(input logic [LANES-1:0] en, input logic [LANES*SW-1:0] s,
                       input logic [LANES*2-1:0] g, input logic [LANES*3-1:0] o);
      @(negedge clk);
      lane_en = en; src_bus = s; gap_bus = g; off_bus = o; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      logic [OW:0] e;
      logic [SW-1:0] pats [5];
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9", '0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", '0, 1'b0, 1'b0);

      // R4 identity
      fire(4'b0001, {96'h0, 32'hA5C3_0F81}, '0, '0);
      check("R4", {96'h0, 32'hA5C3_0F81}, 1'b0, 1'b1);
      @(negedge clk);
      check("R7", {96'h0, 32'hA5C3_0F81}, 1'b0, 1'b0);

      // R1 R2 R3 sweep of every gap/offset pair on each lane position
      pats[0] = 32'hFFFF_FFFF;
      pats[1] = 32'h8000_0000;
      pats[2] = 32'h0000_0001;
      pats[3] = 32'h7FFF_FFFF;
      for (int ln = 0; ln < LANES; ln++) begin
         for (int g = 0; g < 4; g++) begin
            for (int o = 0; o < 8; o++) begin
               for (int p = 0; p < 5; p++) begin
                  logic [LANES*SW-1:0] s = '0;
                  logic [LANES*2-1:0]  gb = '0;
                  logic [LANES*3-1:0]  ob = '0;
                  logic [LANES-1:0]    en = '0;
                  seed = next_rand(seed);
                  pats[4] = seed;
                  s[ln*SW +: SW] = pats[p];
                  gb[ln*2 +: 2] = 2'(g);
                  ob[ln*3 +: 3] = 3'(o);
                  en[ln] = 1'b1;
                  fire(en, s, gb, ob);
                  e = model(en, s, gb, ob);
                  check("R1/R3 placement and drop", e[OW-1:0], e[OW], 1'b1);
               end
            end
         end
      end

      // R3 boundary: lone top bit lands at 127 with G=3 OFF=3, dropped at OFF=4
      fire(4'b0001, {96'h0, 32'h8000_0000}, 8'h03, 12'h003);
      check("R3", {1'b1, 127'h0}, 1'b0, 1'b1);
      fire(4'b0001, {96'h0, 32'h8000_0000}, 8'h03, 12'h004);
      check("R3", '0, 1'b1, 1'b1);
      // R3 dropped bits that are zero raise no flag
      fire(4'b0001, {96'h0, 32'h0000_00FF}, 8'h03, 12'h007);
      check("R3", {120'h0, 8'hFF} == '0 ? '0 : model(4'b0001, {96'h0, 32'h0000_00FF}, 8'h03, 12'h007), 1'b0, 1'b1);

      // R5 disabled lanes contribute nothing, not even the flag
      fire(4'b0101, {32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_00F0},
           8'b11_00_11_01, 12'b111_010_111_001);
      e = model(4'b0101, {32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_00F0},
                8'b11_00_11_01, 12'b111_010_111_001);
      check("R5", e[OW-1:0], e[OW], 1'b1);
      fire(4'b0000, {4{32'hFFFF_FFFF}}, 8'hFF, 12'hFFF);
      check("R5", '0, 1'b0, 1'b1);

      // R6 Morton interleave for M = 2, 3, 4
      for (int m = 2; m <= 4; m++) begin
         for (int rep = 0; rep < 6; rep++) begin
            logic [LANES*SW-1:0] s = '0;
            logic [LANES*2-1:0]  gb = '0;
            logic [LANES*3-1:0]  ob = '0;
            logic [LANES-1:0]    en = '0;
            logic [OW-1:0]       mort = '0;
            for (int j = 0; j < m; j++) begin
               seed = next_rand(seed);
               s[j*SW +: SW] = (rep == 0) ? 32'hFFFF_FFFF : seed;
               gb[j*2 +: 2] = 2'(m - 1);
               ob[j*3 +: 3] = 3'(j);
               en[j] = 1'b1;
            end
            for (int i = 0; i < SW; i++) begin
               for (int j = 0; j < m; j++) begin
                  mort[m*i + j] = s[j*SW + i];
               end
            end
            fire(en, s, gb, ob);
            check("R6", mort, 1'b0, 1'b1);
         end
      end

      // R8 inputs change while idle; outputs hold
      fire(4'b0011, {64'h0, 32'hDEAD_BEEF, 32'h0F0F_0F0F}, 8'h05, 12'h008);
      e = model(4'b0011, {64'h0, 32'hDEAD_BEEF, 32'h0F0F_0F0F}, 8'h05, 12'h008);
      check("R8", e[OW-1:0], e[OW], 1'b1);
      lane_en = 4'b1111; src_bus = {4{32'hFFFF_FFFF}}; gap_bus = 8'hFF; off_bus = 12'hFFF;
      @(negedge clk);
      check("R8", e[OW-1:0], e[OW], 1'b0);
      @(negedge clk);
      check("R8", e[OW-1:0], e[OW], 1'b0);

      // R7 back-to-back requests
      @(negedge clk);
      lane_en = 4'b0001; src_bus = {96'h0, 32'h0000_0003}; gap_bus = '0; off_bus = '0;
      in_valid = 1'b1;
      @(negedge clk);
      check("R7", {126'h0, 2'b11}, 1'b0, 1'b1);
      src_bus = {96'h0, 32'h0000_0005};
      @(negedge clk);
      in_valid = 1'b0;
      check("R7", {125'h0, 3'b101}, 1'b0, 1'b1);
      @(negedge clk);
      check("R7", {125'h0, 3'b101}, 1'b0, 1'b0);

      // R9 reset in the middle of operation clears everything
      rst_n = 1'b0;
      @(negedge clk);
      check("R9", '0, 1'b0, 1'b0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule